// File: doc/BRIEF.md
# Per-Lane Write Data Delay Sweep Calibrator

This block aligns the write data of a multi-lane memory interface to the clock forwarded with that data. It works on one byte lane at a time. For each lane it first selects the lane's data delay element and resets it to tap 0. It then adds one tap at a time. After each tap change it waits a programmable settle time and takes one pass/fail compare result from an external pattern checker. The forwarded clock's own delay is never swept. It stays at a preset starting tap, and that preset is driven out for the clock-path delay element to load.

A lane's sweep ends at the first tap where the compare result differs from the result at the previous tap, or at the last tap of the fine delay range, whichever comes first. The block then stores three things for the lane: a final tap setting, the number of passing taps it saw, and an error flag that is set when no tap passed. All three can be read back at any time through a lane-indexed read port. Once every lane has a result, the block asks for the read calibration to run again with the new write timing. It raises a single-cycle done pulse after that request is acknowledged.

Top module: `wr_lane_cal`

## Requirements
- R1: A high `start_i` while idle starts calibration and raises `busy_o`. Lanes are visited one at a time in ascending order from 0. `lane_en_o` is high and `lane_sel_o` holds the lane's index through all tap pulses for that lane. The first pulse for each lane is `tap_rst_o`.
- R2: `ref_tap_o` always drives the preset clock-path tap (default 32), from reset onward, and does not change during a sweep.
- R3: Each lane's sweep starts at tap 0, set by a one-cycle `tap_rst_o` pulse. Each one-cycle `tap_inc_o` pulse moves the data delay up by exactly one tap. `tap_rst_o` and `tap_inc_o` are never high together.
- R4: Counting the cycle of a tap pulse as cycle 0, `cmp_valid_i` and `cmp_pass_i` are ignored in cycles 0 through `settle_cycles_i`+1. After that, the first cycle with `cmp_valid_i` high supplies the single result for the tap (`cmp_pass_i` high = pass).
- R5: The sweep of a lane stops at the first tap whose result differs from the result at the previous tap. On a pass-to-fail change, the final tap is the previous tap. On a fail-to-pass change, the final tap is the current tap.
- R6: If no change is seen, the sweep stops after sampling tap `MAX_TAP` (default 63) and the final tap is `MAX_TAP`. No lane ever receives more than `MAX_TAP` increments, so the tap never wraps.
- R7: The stored margin of a lane is the number of passing results sampled during its sweep.
- R8: If a lane saw no passing result, its error flag is set, and calibration still goes on to the next lane.
- R9: `rdcal_req_o` rises only after every lane's result is stored. It stays high until a cycle in which `rdcal_ack_i` is high.
- R10: `done_o` is high for exactly one cycle, namely the cycle after the acknowledge. In the following cycle `busy_o` is low.
- R11: `rd_final_tap_o`, `rd_margin_o` and `rd_err_o` show, combinationally, the stored result of lane `rd_lane_i`. Reset clears all stored results to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a calibration run |
| settle_cycles_i | input | SETTLE_W | Extra settle cycles after each tap change |
| lane_sel_o | output | LANE_W | Lane whose data delay is being adjusted |
| lane_en_o | output | 1 | Lane selection valid |
| ref_tap_o | output | TAP_W | Fixed tap for the forwarded clock path |
| tap_rst_o | output | 1 | Reset the selected lane's data tap to 0 |
| tap_inc_o | output | 1 | Add one tap to the selected lane's data delay |
| cmp_valid_i | input | 1 | Compare result strobe |
| cmp_pass_i | input | 1 | Compare result, 1 = pass |
| rdcal_req_o | output | 1 | Request to rerun read calibration |
| rdcal_ack_i | input | 1 | Read calibration rerun acknowledge |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_lane_i | input | LANE_W | Result read index |
| rd_final_tap_o | output | TAP_W | Stored final tap of the read lane |
| rd_margin_o | output | TAP_W+1 | Stored passing-tap count of the read lane |
| rd_err_o | output | 1 | Stored no-pass error flag of the read lane |

## Verification
The hardest case to reach from the ports is a compare result taken one cycle too early during settling. A correct design and a slightly wrong one see the same stable compare value, so a wrong settle count hides behind correct results. To expose it, the bench tracks its own copy of the data tap from the tap pulses. Through the whole ignore window it drives a valid strobe with the inverted pass value. Only after that window does it give the true window response, with the strobe randomly withheld. Any early sample then changes the stored final tap or margin. Lane windows are chosen to hit a window starting at tap 0, a window starting later, an empty lane, a fully passing lane and a single-tap window at the top of the range.

// File: rtl/wcal_pkg.sv
package wcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_SETTLE,
    ST_SAMPLE,
    ST_STEP,
    ST_STORE,
    ST_RDCAL,
    ST_DONE
  } wcal_state_e;
endpackage

// File: rtl/wcal_settle_timer.sv
module wcal_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic [SETTLE_W-1:0] limit_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  assign expired_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (!expired_o)    cnt_q <= cnt_q + SETTLE_W'(1);
  end
endmodule

// File: rtl/wcal_sweep_track.sv
module wcal_sweep_track #(
  parameter int TAP_W   = 6,
  parameter int MAX_TAP = 63,
  localparam int MRG_W  = TAP_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             sample_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             end_o,
  output logic [TAP_W-1:0] final_o,
  output logic [MRG_W-1:0] margin_o,
  output logic             err_o
);
  logic             prev_pass_q;
  logic [TAP_W-1:0] final_q;
  logic [MRG_W-1:0] margin_q;
  logic             edge_hit, at_top;

  assign edge_hit = (tap_i != '0) && (pass_i != prev_pass_q);
  assign at_top   = (tap_i == TAP_W'(MAX_TAP));
  assign end_o    = sample_i && (edge_hit || at_top);
  assign final_o  = final_q;
  assign margin_o = margin_q;
  assign err_o    = (margin_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_pass_q <= 1'b0;
      final_q     <= '0;
      margin_q    <= '0;
    end else if (clear_i) begin
      prev_pass_q <= 1'b0;
      final_q     <= '0;
      margin_q    <= '0;
    end else if (sample_i) begin
      prev_pass_q <= pass_i;
      margin_q    <= margin_q + {{(MRG_W-1){1'b0}}, pass_i};
      if (edge_hit)    final_q <= prev_pass_q ? (tap_i - TAP_W'(1)) : tap_i;
      else if (at_top) final_q <= TAP_W'(MAX_TAP);
    end
  end
endmodule

// File: rtl/wcal_result_rf.sv
module wcal_result_rf #(
  parameter int NUM_LANES = 4,
  parameter int TAP_W     = 6,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int MRG_W    = TAP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [LANE_W-1:0] wr_lane_i,
  input  logic [TAP_W-1:0]  wr_final_i,
  input  logic [MRG_W-1:0]  wr_margin_i,
  input  logic              wr_err_i,
  input  logic [LANE_W-1:0] rd_lane_i,
  output logic [TAP_W-1:0]  rd_final_o,
  output logic [MRG_W-1:0]  rd_margin_o,
  output logic              rd_err_o
);
  logic [TAP_W-1:0] final_q  [NUM_LANES];
  logic [MRG_W-1:0] margin_q [NUM_LANES];
  logic             err_q    [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        final_q[g]  <= '0;
        margin_q[g] <= '0;
        err_q[g]    <= 1'b0;
      end else if (we_i && (wr_lane_i == LANE_W'(g))) begin
        final_q[g]  <= wr_final_i;
        margin_q[g] <= wr_margin_i;
        err_q[g]    <= wr_err_i;
      end
    end
  end

  always_comb begin
    rd_final_o  = '0;
    rd_margin_o = '0;
    rd_err_o    = 1'b0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (rd_lane_i == LANE_W'(i)) begin
        rd_final_o  = final_q[i];
        rd_margin_o = margin_q[i];
        rd_err_o    = err_q[i];
      end
    end
  end
endmodule

// File: rtl/wr_lane_cal.sv
module wr_lane_cal
  import wcal_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int MAX_TAP   = 63,
  parameter int REF_TAP   = 32,
  parameter int SETTLE_W  = 8,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int TAP_W    = $clog2(MAX_TAP + 1),
  localparam int MRG_W    = TAP_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic [LANE_W-1:0]   lane_sel_o,
  output logic                lane_en_o,
  output logic [TAP_W-1:0]    ref_tap_o,
  output logic                tap_rst_o,
  output logic                tap_inc_o,
  input  logic                cmp_valid_i,
  input  logic                cmp_pass_i,
  output logic                rdcal_req_o,
  input  logic                rdcal_ack_i,
  output logic                busy_o,
  output logic                done_o,
  input  logic [LANE_W-1:0]   rd_lane_i,
  output logic [TAP_W-1:0]    rd_final_tap_o,
  output logic [MRG_W-1:0]    rd_margin_o,
  output logic                rd_err_o
);
  wcal_state_e       state_q, state_d;
  logic [LANE_W-1:0] lane_q;
  logic [TAP_W-1:0]  tap_q;
  logic              settle_done, sample, sweep_end, store;
  logic [TAP_W-1:0]  trk_final;
  logic [MRG_W-1:0]  trk_margin;
  logic              trk_err;
  logic              last_lane;

  assign last_lane = (lane_q == LANE_W'(NUM_LANES - 1));
  assign sample    = (state_q == ST_SAMPLE) && cmp_valid_i;
  assign store     = (state_q == ST_STORE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_SELECT;
      ST_SELECT: state_d = ST_SETTLE;
      ST_SETTLE: if (settle_done) state_d = ST_SAMPLE;
      ST_SAMPLE: if (sample) state_d = sweep_end ? ST_STORE : ST_STEP;
      ST_STEP:   state_d = ST_SETTLE;
      ST_STORE:  state_d = last_lane ? ST_RDCAL : ST_SELECT;
      ST_RDCAL:  if (rdcal_ack_i) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      tap_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) lane_q <= '0;
      else if (store && !last_lane)      lane_q <= lane_q + LANE_W'(1);
      if (state_q == ST_SELECT)          tap_q <= '0;
      else if (state_q == ST_STEP && tap_q != TAP_W'(MAX_TAP)) tap_q <= tap_q + TAP_W'(1);
    end
  end

  wcal_settle_timer #(.SETTLE_W(SETTLE_W)) i_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (tap_rst_o | tap_inc_o),
    .limit_i   (settle_cycles_i),
    .expired_o (settle_done)
  );

  wcal_sweep_track #(.TAP_W(TAP_W), .MAX_TAP(MAX_TAP)) i_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (tap_rst_o),
    .sample_i (sample),
    .pass_i   (cmp_pass_i),
    .tap_i    (tap_q),
    .end_o    (sweep_end),
    .final_o  (trk_final),
    .margin_o (trk_margin),
    .err_o    (trk_err)
  );

  wcal_result_rf #(.NUM_LANES(NUM_LANES), .TAP_W(TAP_W)) i_rf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (store),
    .wr_lane_i   (lane_q),
    .wr_final_i  (trk_final),
    .wr_margin_i (trk_margin),
    .wr_err_i    (trk_err),
    .rd_lane_i   (rd_lane_i),
    .rd_final_o  (rd_final_tap_o),
    .rd_margin_o (rd_margin_o),
    .rd_err_o    (rd_err_o)
  );

  assign lane_sel_o  = lane_q;
  assign lane_en_o   = (state_q == ST_SELECT) || (state_q == ST_SETTLE) ||
                       (state_q == ST_SAMPLE) || (state_q == ST_STEP) || store;
  assign ref_tap_o   = TAP_W'(REF_TAP);
  assign tap_rst_o   = (state_q == ST_SELECT);
  assign tap_inc_o   = (state_q == ST_STEP);
  assign rdcal_req_o = (state_q == ST_RDCAL);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/wcal_checker.sv
module wcal_checker #(
  parameter int NUM_LANES = 4,
  parameter int MAX_TAP   = 63,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int CNT_W    = $clog2(MAX_TAP + 1) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tap_rst_o,
  input logic              tap_inc_o,
  input logic              lane_en_o,
  input logic [LANE_W-1:0] lane_sel_o,
  input logic              rdcal_req_o,
  input logic              rdcal_ack_i,
  input logic              busy_o,
  input logic              done_o
);
  logic [CNT_W-1:0] inc_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        inc_cnt_q <= '0;
    else if (tap_rst_o) inc_cnt_q <= '0;
    else if (tap_inc_o) inc_cnt_q <= inc_cnt_q + CNT_W'(1);
  end

  a_r3_pulses_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tap_rst_o, tap_inc_o}));

  a_r1_inc_needs_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_inc_o |-> (lane_en_o && $stable(lane_sel_o)));

  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_inc_o |-> (inc_cnt_q < CNT_W'(MAX_TAP)));

  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdcal_req_o && !rdcal_ack_i) |=> rdcal_req_o);

  a_r10_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdcal_req_o && rdcal_ack_i) |=> done_o);

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  a_r9_req_no_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdcal_req_o |-> !lane_en_o);
endmodule

bind wr_lane_cal wcal_checker #(.NUM_LANES(NUM_LANES), .MAX_TAP(MAX_TAP)) i_wcal_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tap_rst_o   (tap_rst_o),
  .tap_inc_o   (tap_inc_o),
  .lane_en_o   (lane_en_o),
  .lane_sel_o  (lane_sel_o),
  .rdcal_req_o (rdcal_req_o),
  .rdcal_ack_i (rdcal_ack_i),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/test_wr_lane_cal.sv
module test_wr_lane_cal;
  localparam int NUM_LANES = 4;
  localparam int MAX_TAP   = 63;
  localparam int REF_TAP   = 32;
  localparam int SETTLE_W  = 8;
  localparam int LANE_W    = 2;
  localparam int TAP_W     = 6;

  logic clk = 0, rst_n = 0;
  logic start = 0, cmp_valid = 0, cmp_pass = 0, rdcal_ack = 0;
  logic [SETTLE_W-1:0] settle = '0;
  logic [LANE_W-1:0] rd_lane = '0;
  logic [LANE_W-1:0] lane_sel;
  logic lane_en, tap_rst, tap_inc, rdcal_req, busy, done, rd_err;
  logic [TAP_W-1:0] ref_tap, rd_final;
  logic [TAP_W:0] rd_margin;

  int checks = 0, errors = 0;
  int win_lo[NUM_LANES], win_hi[NUM_LANES];
  int lanes_seen = 0, cur_lane = 0, mtap = 0, age = 0;
  logic req_prev = 0, finished = 0;

  always #5 clk = ~clk;

  wr_lane_cal #(.NUM_LANES(NUM_LANES), .MAX_TAP(MAX_TAP), .REF_TAP(REF_TAP), .SETTLE_W(SETTLE_W)) i_wr_lane_cal (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_cycles_i(settle),
    .lane_sel_o(lane_sel), .lane_en_o(lane_en), .ref_tap_o(ref_tap),
    .tap_rst_o(tap_rst), .tap_inc_o(tap_inc), .cmp_valid_i(cmp_valid), .cmp_pass_i(cmp_pass),
    .rdcal_req_o(rdcal_req), .rdcal_ack_i(rdcal_ack), .busy_o(busy), .done_o(done),
    .rd_lane_i(rd_lane), .rd_final_tap_o(rd_final), .rd_margin_o(rd_margin), .rd_err_o(rd_err));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit lane_pass(int lane, int t);
    return (t >= win_lo[lane]) && (t <= win_hi[lane]);
  endfunction

  // expected sweep result from the requirement rules
  task automatic expect_lane(input int lane, output int fin, output int mrg, output int err);
    bit prev = 0;
    fin = MAX_TAP; mrg = 0;
    for (int t = 0; t <= MAX_TAP; t++) begin
      bit p = lane_pass(lane, t);
      if (p) mrg++;
      if (t > 0 && p != prev) begin
        fin = prev ? t - 1 : t;
        break;
      end
      prev = p;
    end
    err = (mrg == 0);
  endtask

  // compare source model: tracks data tap from pulses, corrupts results while settling
  always @(negedge clk) begin
    if (!rst_n) begin
      cmp_valid <= 0; cmp_pass <= 0;
    end else begin
      if (tap_rst) begin
        check(lane_en && lane_sel == LANE_W'(lanes_seen), "R1 lane order", lane_sel, lanes_seen);
        cur_lane = lanes_seen; lanes_seen++; mtap = 0; age = 0;
      end else if (tap_inc) begin
        check(lane_en && lane_sel == LANE_W'(cur_lane) && mtap < MAX_TAP, "R6 tap limit / R1 lane hold", mtap, MAX_TAP - 1);
        mtap++; age = 0;
      end else if (age < 1000) age++;
      if (rdcal_req && !req_prev)
        check(lanes_seen == NUM_LANES, "R9 request after all lanes", lanes_seen, NUM_LANES);
      req_prev = rdcal_req;
      if (age <= int'(settle) + 1) begin
        cmp_valid <= 1;
        cmp_pass  <= !lane_pass(cur_lane, mtap);
      end else if ($urandom % 4 != 0) begin
        cmp_valid <= 1;
        cmp_pass  <= lane_pass(cur_lane, mtap);
      end else begin
        cmp_valid <= 0;
        cmp_pass  <= !lane_pass(cur_lane, mtap);
      end
    end
  end

  task automatic run_cal(input int s);
    int dly;
    settle = SETTLE_W'(s);
    lanes_seen = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(busy, "R1 busy after start", busy, 1);
    while (!rdcal_req) @(negedge clk);
    dly = $urandom % 4;
    repeat (dly) begin
      @(negedge clk);
      check(rdcal_req && !done, "R9 request held", rdcal_req, 1);
    end
    rdcal_ack = 1;
    @(negedge clk) rdcal_ack = 0;
    check(done && !rdcal_req, "R10 done pulse", done, 1);
    @(negedge clk);
    check(!done && !busy, "R10 done single/idle", done, 0);
    check(ref_tap == TAP_W'(REF_TAP), "R2 clock tap", ref_tap, REF_TAP);
    for (int l = 0; l < NUM_LANES; l++) begin
      int fin, mrg, err;
      expect_lane(l, fin, mrg, err);
      rd_lane = LANE_W'(l);
      #1;
      check(rd_final == TAP_W'(fin), "R5 R6 R11 final tap", rd_final, fin);
      check(rd_margin == (TAP_W+1)'(mrg), "R4 R7 margin", rd_margin, mrg);
      check(rd_err == err[0], "R8 error flag", rd_err, err);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rdcal_req && !lane_en && !tap_rst && !tap_inc, "R1 reset idle", busy, 0);
    check(ref_tap == TAP_W'(REF_TAP), "R2 clock tap in reset", ref_tap, REF_TAP);
    rst_n = 1;
    @(negedge clk);
    for (int l = 0; l < NUM_LANES; l++) begin
      rd_lane = LANE_W'(l);
      #1;
      check(rd_final == 0 && rd_margin == 0 && !rd_err, "R11 reset contents", rd_margin, 0);
    end
    void'($urandom(32'h5eed_0042));
    // directed: pass->fail, fail->pass, empty, full
    win_lo = '{0, 20, 1, 0}; win_hi = '{10, 40, 0, 63};
    run_cal(0);
    // directed: single tap at 0, single tap at top, late start, top pair
    win_lo = '{0, 63, 5, 62}; win_hi = '{0, 63, 63, 63};
    run_cal(3);
    for (int r = 0; r < 6; r++) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if ($urandom % 6 == 0) begin win_lo[l] = 1; win_hi[l] = 0; end
        else begin
          win_lo[l] = ($urandom % 3 == 0) ? 0 : int'($urandom % (MAX_TAP + 1));
          win_hi[l] = win_lo[l] + int'($urandom % (MAX_TAP + 1 - win_lo[l]));
        end
      end
      run_cal(int'($urandom % 6));
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule